// File: doc/BRIEF.md
# Relocatable Memory Array Bus Interface

This block is a bus slave placed in front of a 4-Kbyte non-volatile memory array, modelled here as registers. Software places the array window on any 4-Kbyte boundary by writing two base-address registers, can limit the window to program-space accesses only, and sets a wait-state count that stretches every array access. A small register block sits at a fixed address, `REG_BASE`, and is always reachable. It holds configuration, the base address, a control/arming register and a three-word shadow row.

Reads may be byte, word or long-word, and are returned big-endian on `busRdata`. Writes program the array or start an erase. Programming can only clear bits. Erase works either on one 1-Kbyte block or on the whole array together with the shadow row. Both require an armed control register and the external program/erase voltage enable. On a system reset the configuration and base registers reload from the shadow row. An alternate-owner mode can take the array off the bus, but it cannot be entered while programming or erasing is armed.

Top module: `reloc_array_slave`

## Requirements
- R1: The array acknowledges an access only when busAddr[23:12] equals {BASEH[7:0], BASEL[15:12]}. BASEH is at REG_BASE+2 and BASEL at REG_BASE+4. Any other address outside the register block gets no busAck.
- R2: When CFG (REG_BASE+0) bit 14 is set, array accesses with busProgSpace=0 are not acknowledged. Program-space accesses are still answered.
- R3: Cycles are counted from the first cycle with busReq high, and busAck is high in the last of them. A register access takes 2 cycles. An array byte or word access takes 2+W cycles, where W = CFG[1:0]. An array long-word access takes 2*(2+W) cycles.
- R4: Read data is big-endian. A byte is returned in busRdata[7:0], a word (even address) in busRdata[15:0], and a long word (address multiple of 4) as {byte a, a+1, a+2, a+3}. Unused upper bits are zero.
- R5: Programming stores old AND new data. Bit 0 of CTL (REG_BASE+6) arms it. It works on byte or aligned word writes to the window.
- R6: An array write changes nothing and sets the sticky error flag CTL bit 7 in any of these cases: pgmVoltEn is low, neither program (CTL bit 0) nor erase (CTL bit 1) is armed, or both are armed.
- R7: The following complete with no change to the array and set CTL bit 7: a word access at an odd address, a long-word access not on a multiple of 4, and any long-word write. Misaligned reads return 0. Writing CTL with bit 7 set clears the flag.
- R8: With only erase armed and pgmVoltEn high, a write in the window erases, setting every byte to 0xFF. Without CTL bit 2 it erases the 1-Kbyte block selected by busAddr[11:10]. With CTL bit 2 set it erases the whole array and the shadow row.
- R9: A CFG write setting bit 13 (alternate owner) is refused while CTL bit 0 or bit 1 is set. While the mode is active, ownerMode is high, the array is not acknowledged, registers still answer, and CTL arming bits cannot be set.
- R10: The shadow words at REG_BASE+8, +A and +C hold the defaults for CFG, BASEH and BASEL. They are programmed only by ANDing, and only with program armed and pgmVoltEn high. While rstN is low, CFG bits 14 and 1:0, BASEH and BASEL load from the shadow row. CTL and bit 13 clear.
- R11: At reset, CFG bit 15 (stop) loads as shadow bit 15 AND NOT strapEn. While stop is set, the array is not acknowledged.
- R12: While porN is low, the array and the shadow row become all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous system reset, active low; reloads registers from the shadow row |
| porN | input | 1 | Power-on initialisation of the storage model to the erased state, active low |
| strapEn | input | 1 | Reset-time enable strap; high forces the array enabled |
| pgmVoltEn | input | 1 | External program/erase voltage present |
| busReq | input | 1 | Access request, held until busAck |
| busAddr | input | 24 | Byte address |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSize | input | 2 | 0 byte, 1 word, 2 or 3 long word |
| busProgSpace | input | 1 | 1 = program space, 0 = data space |
| busWdata | input | 32 | Write data, right-aligned |
| busAck | output | 1 | Access completes in this cycle |
| busRdata | output | 32 | Read data, valid with busAck |
| ownerMode | output | 1 | Alternate-owner mode active |

## Verification
A wrong base, space or stop setting shows as a missing busAck. It appears within ten cycles of the request, so the bench treats a 20-cycle silence as "not acknowledged" and compares that against the window it computed itself. A wrong wait-state or access-length count shows directly as busAck arriving in the wrong cycle, and every size is swept against every wait setting. A corrupted cell, a bad program mask, or an erase applied to the wrong block stays hidden until that location is read back. For that reason every program or erase is followed by readback of the touched locations and of neighbours that must stay intact. Shadow-row faults appear only after the next rstN pulse, through register reads.

// File: rtl/rma_pkg.sv
package rma_pkg;
  typedef struct packed {
    logic progArr;
    logic eraseBlk;
    logic eraseAll;
    logic progShadow;
  } dp_strobe_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
endpackage

// File: rtl/rma_datapath.sv
module rma_datapath
  import rma_pkg::*;
#(
  parameter int WIN_BITS = 12,
  parameter int BLK_BITS = 10
) (
  input  logic                clk,
  input  logic                porN,
  input  dp_strobe_t          stb,
  input  logic [WIN_BITS-1:0] offs,
  input  logic [1:0]          size,
  input  logic [31:0]         wdata,
  input  logic [1:0]          shadowSel,
  output logic [31:0]         rdData,
  output logic [15:0]         shadowCfg,
  output logic [15:0]         shadowBaseH,
  output logic [15:0]         shadowBaseL
);
  localparam int WORDS = (2 ** WIN_BITS) / 4;
  localparam int IDX_W = WIN_BITS - 2;
  localparam int BSH   = BLK_BITS - 2;

  logic [31:0] mem [WORDS];
  logic [15:0] shadow [4];

  logic [IDX_W-1:0] wordIdx;
  logic [31:0]      curWord;
  logic [4:0]       laneShift;
  logic [31:0]      laneMask;
  logic [31:0]      laneData;
  logic [31:0]      newWord;

  assign wordIdx   = offs[WIN_BITS-1:2];
  assign curWord   = mem[wordIdx];
  assign laneShift = {~offs[1:0], 3'b000};

  // read lane selection, big-endian within the stored word
  always_comb begin
    unique case (size)
      SZ_BYTE: rdData = {24'b0, curWord[laneShift +: 8]};
      SZ_WORD: rdData = offs[1] ? {16'b0, curWord[15:0]} : {16'b0, curWord[31:16]};
      default: rdData = curWord;
    endcase
  end

  // program mask: bits can only be cleared
  always_comb begin
    if (size == SZ_BYTE) begin
      laneMask = 32'hFF << laneShift;
      laneData = {24'b0, wdata[7:0]} << laneShift;
    end else if (offs[1]) begin
      laneMask = 32'h0000_FFFF;
      laneData = {16'b0, wdata[15:0]};
    end else begin
      laneMask = 32'hFFFF_0000;
      laneData = {wdata[15:0], 16'b0};
    end
    newWord = curWord & (~laneMask | laneData);
  end

  always_ff @(posedge clk) begin
    if (!porN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
      for (int s = 0; s < 4; s++) shadow[s] <= '1;
    end else begin
      if (stb.progArr) mem[wordIdx] <= newWord;
      if (stb.eraseBlk) begin
        for (int i = 0; i < WORDS; i++)
          if ((IDX_W'(i) >> BSH) == (wordIdx >> BSH)) mem[i] <= '1;
      end
      if (stb.eraseAll) begin
        for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        for (int s = 0; s < 4; s++) shadow[s] <= '1;
      end else if (stb.progShadow) begin
        shadow[shadowSel] <= shadow[shadowSel] & wdata[15:0];
      end
    end
  end

  assign shadowCfg   = shadow[0];
  assign shadowBaseH = shadow[1];
  assign shadowBaseL = shadow[2];
endmodule

// File: rtl/rma_ctrl.sv
module rma_ctrl
  import rma_pkg::*;
#(
  parameter int                ADDR_W   = 24,
  parameter int                WIN_BITS = 12,
  parameter int                WAIT_W   = 2,
  parameter logic [ADDR_W-1:0] REG_BASE = 24'h7FF800
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapEn,
  input  logic              pgmVoltEn,
  input  logic              busReq,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  logic              busProgSpace,
  input  logic [31:0]       busWdata,
  input  logic [31:0]       dpRdata,
  input  logic [15:0]       shadowCfg,
  input  logic [15:0]       shadowBaseH,
  input  logic [15:0]       shadowBaseL,
  output logic              busAck,
  output logic [31:0]       busRdata,
  output dp_strobe_t        dpStb,
  output logic [1:0]        shadowSel,
  output logic              ownerMode,
  output logic              armed,
  output logic              regHit
);
  localparam int HI_W  = ADDR_W - 16;
  localparam int LO_W  = 16 - WIN_BITS;
  localparam int MAX_T = 2 * (2 + (2 ** WAIT_W) - 1);
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic              stopBit, progOnly, ownerBit;
  logic [WAIT_W-1:0] waitSt;
  logic [HI_W-1:0]   baseHi;
  logic [LO_W-1:0]   baseLo;
  logic              armPgm, armErs, armBulk, errFlag;
  logic [CNT_W-1:0]  cycCnt;

  logic             winHit, arrHit, anyHit, isLong, isWord, misAl;
  logic [CNT_W-1:0] baseT, target;
  logic [2:0]       regIdx;
  logic             arrWr, wrBad, shWr, shBad, regWr, errSet;
  logic [15:0]      regWord;

  assign regHit = busAddr[ADDR_W-1:4] == REG_BASE[ADDR_W-1:4];
  assign winHit = busAddr[ADDR_W-1:WIN_BITS] == {baseHi, baseLo};
  assign arrHit = !regHit && winHit && !stopBit && !ownerBit && (busProgSpace || !progOnly);
  assign anyHit = regHit || arrHit;
  assign isLong = busSize[1];
  assign isWord = busSize == SZ_WORD;
  assign misAl  = isLong ? (busAddr[1:0] != 2'b00) : (isWord && busAddr[0]);
  assign regIdx = busAddr[3:1];

  // access length: one bus cycle is 2 clocks plus wait states, long words take two
  assign baseT  = CNT_W'(2) + CNT_W'(waitSt);
  assign target = regHit ? CNT_W'(2) : (isLong ? (baseT << 1) : baseT);
  assign busAck = busReq && anyHit && (cycCnt == target - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN || !busReq || !anyHit || busAck) cycCnt <= '0;
    else                                       cycCnt <= cycCnt + CNT_W'(1);
  end

  // write classification
  assign arrWr = busAck && arrHit && busWrite;
  assign wrBad = misAl || isLong || !(armPgm ^ armErs) || !pgmVoltEn;
  assign regWr = busAck && regHit && busWrite;
  assign shWr  = regWr && regIdx[2] && (regIdx[1:0] != 2'b11);
  assign shBad = !armPgm || armErs || !pgmVoltEn;
  assign errSet = busAck && ((arrHit && (misAl || (busWrite && wrBad))) || (shWr && shBad));

  always_comb begin
    dpStb            = '0;
    dpStb.progArr    = arrWr && !wrBad && armPgm;
    dpStb.eraseBlk   = arrWr && !wrBad && armErs && !armBulk;
    dpStb.eraseAll   = arrWr && !wrBad && armErs && armBulk;
    dpStb.progShadow = shWr && !shBad;
  end
  assign shadowSel = regIdx[1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopBit  <= shadowCfg[15] & ~strapEn;
      progOnly <= shadowCfg[14];
      waitSt   <= shadowCfg[WAIT_W-1:0];
      ownerBit <= 1'b0;
      baseHi   <= shadowBaseH[HI_W-1:0];
      baseLo   <= shadowBaseL[15:WIN_BITS];
      armPgm   <= 1'b0;
      armErs   <= 1'b0;
      armBulk  <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (regWr) begin
        unique case (regIdx)
          3'd0: begin
            stopBit  <= busWdata[15];
            progOnly <= busWdata[14];
            ownerBit <= busWdata[13] & ~(armPgm | armErs);
            waitSt   <= busWdata[WAIT_W-1:0];
          end
          3'd1: baseHi <= busWdata[HI_W-1:0];
          3'd2: baseLo <= busWdata[15:WIN_BITS];
          3'd3: begin
            armPgm  <= busWdata[0] & ~ownerBit;
            armErs  <= busWdata[1] & ~ownerBit;
            armBulk <= busWdata[2];
          end
          default: ;
        endcase
      end
      if (errSet)                                         errFlag <= 1'b1;
      else if (regWr && regIdx == 3'd3 && busWdata[7])    errFlag <= 1'b0;
    end
  end

  always_comb begin
    unique case (regIdx)
      3'd0:    regWord = {stopBit, progOnly, ownerBit, {(13 - WAIT_W){1'b0}}, waitSt};
      3'd1:    regWord = {{(16 - HI_W){1'b0}}, baseHi};
      3'd2:    regWord = {baseLo, {WIN_BITS{1'b0}}};
      3'd3:    regWord = {8'b0, errFlag, 4'b0, armBulk, armErs, armPgm};
      3'd4:    regWord = shadowCfg;
      3'd5:    regWord = shadowBaseH;
      3'd6:    regWord = shadowBaseL;
      default: regWord = 16'h0000;
    endcase
  end

  assign busRdata  = regHit ? {16'b0, regWord} : (misAl ? 32'b0 : dpRdata);
  assign ownerMode = ownerBit;
  assign armed     = armPgm | armErs;
endmodule

// File: rtl/reloc_array_slave.sv
module reloc_array_slave
  import rma_pkg::*;
#(
  parameter int           ADDR_W   = 24,
  parameter int           WIN_BITS = 12,
  parameter int           BLK_BITS = 10,
  parameter int           WAIT_W   = 2,
  parameter logic [23:0]  REG_BASE = 24'h7FF800
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  logic              strapEn,
  input  logic              pgmVoltEn,
  input  logic              busReq,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  logic              busProgSpace,
  input  logic [31:0]       busWdata,
  output logic              busAck,
  output logic [31:0]       busRdata,
  output logic              ownerMode
);
  dp_strobe_t  dpStb;
  logic [1:0]  shadowSel;
  logic [31:0] dpRdata;
  logic [15:0] shadowCfg, shadowBaseH, shadowBaseL;
  logic        armed, regHit;

  rma_ctrl #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .WAIT_W(WAIT_W), .REG_BASE(REG_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .strapEn(strapEn), .pgmVoltEn(pgmVoltEn),
    .busReq(busReq), .busAddr(busAddr), .busWrite(busWrite), .busSize(busSize),
    .busProgSpace(busProgSpace), .busWdata(busWdata), .dpRdata(dpRdata),
    .shadowCfg(shadowCfg), .shadowBaseH(shadowBaseH), .shadowBaseL(shadowBaseL),
    .busAck(busAck), .busRdata(busRdata), .dpStb(dpStb), .shadowSel(shadowSel),
    .ownerMode(ownerMode), .armed(armed), .regHit(regHit)
  );

  rma_datapath #(
    .WIN_BITS(WIN_BITS), .BLK_BITS(BLK_BITS)
  ) u_dp (
    .clk(clk), .porN(porN), .stb(dpStb), .offs(busAddr[WIN_BITS-1:0]),
    .size(busSize), .wdata(busWdata), .shadowSel(shadowSel), .rdData(dpRdata),
    .shadowCfg(shadowCfg), .shadowBaseH(shadowBaseH), .shadowBaseL(shadowBaseL)
  );
endmodule

// File: rtl/rma_checker.sv
module rma_checker
  import rma_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       busReq,
  input logic       busAck,
  input logic       pgmVoltEn,
  input logic       ownerMode,
  input logic       armed,
  input logic       regHit,
  input dp_strobe_t dpStb
);
  // R3: no access finishes in fewer than two cycles
  p_ack_after_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    busAck |-> (busReq && $past(busReq)));

  // R3: an acknowledge is never repeated in the following cycle
  p_single_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    busAck |=> !busAck);

  // R6: storage changes only during an acknowledged access with voltage present
  p_volt_interlock_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dpStb.progArr || dpStb.eraseBlk || dpStb.eraseAll || dpStb.progShadow)
      |-> (pgmVoltEn && busAck));

  // R9: owner mode is entered only when nothing was armed
  p_owner_refused_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ownerMode) |-> !$past(armed));

  // R9: in owner mode only the register block answers
  p_owner_regs_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busAck && ownerMode) |-> regHit);

  // R8: at most one kind of storage update per cycle
  p_one_update_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dpStb.progArr, dpStb.eraseBlk, dpStb.eraseAll, dpStb.progShadow}));
endmodule

bind reloc_array_slave rma_checker u_chk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busAck(busAck), .pgmVoltEn(pgmVoltEn),
  .ownerMode(ownerMode), .armed(armed), .regHit(regHit), .dpStb(dpStb)
);

// File: tb/tb_reloc_array_slave.sv
module tb_reloc_array_slave;
  localparam int          CLK_PERIOD = 10;
  localparam logic [23:0] REG = 24'h7FF800;

  logic        clk = 1'b0;
  logic        rstN, porN, strapEn, pgmVoltEn;
  logic        busReq, busWrite, busProgSpace;
  logic [23:0] busAddr;
  logic [1:0]  busSize;
  logic [31:0] busWdata;
  logic        busAck;
  logic [31:0] busRdata;
  logic        ownerMode;

  int nRun = 0;
  int nFail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  reloc_array_slave dut (
    .clk(clk), .rstN(rstN), .porN(porN), .strapEn(strapEn), .pgmVoltEn(pgmVoltEn),
    .busReq(busReq), .busAddr(busAddr), .busWrite(busWrite), .busSize(busSize),
    .busProgSpace(busProgSpace), .busWdata(busWdata), .busAck(busAck),
    .busRdata(busRdata), .ownerMode(ownerMode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access; cyc = cycle of busAck counted from the first request cycle, 0 if none
  task automatic acc(input logic [23:0] a, input logic [1:0] sz, input logic wr,
                     input logic ps, input logic [31:0] wd,
                     output logic [31:0] rd, output int cyc);
    @(negedge clk);
    busAddr = a; busSize = sz; busWrite = wr; busProgSpace = ps; busWdata = wd;
    busReq = 1'b1;
    cyc = 0; rd = '0;
    for (int n = 1; n <= 20; n++) begin
      #1;
      if (busAck) begin cyc = n; rd = busRdata; break; end
      @(negedge clk);
    end
    if (cyc != 0) begin @(posedge clk); #1; end
    busReq = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] off, output logic [31:0] d);
    int c;
    acc(REG + 24'(off), 2'd1, 1'b0, 1'b0, '0, d, c);
  endtask

  task automatic wrReg(input logic [3:0] off, input logic [15:0] v);
    logic [31:0] d; int c;
    acc(REG + 24'(off), 2'd1, 1'b1, 1'b0, {16'b0, v}, d, c);
  endtask

  task automatic rstPulse(input logic strap);
    @(negedge clk); strapEn = strap; rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int c;
    busReq = 0; busWrite = 0; busProgSpace = 0; busAddr = '0; busSize = '0; busWdata = '0;
    rstN = 0; porN = 0; strapEn = 1; pgmVoltEn = 0;
    repeat (4) @(negedge clk);
    porN = 1; rstN = 1;

    // reset state from erased shadow row (R12, R10, R11)
    acc(REG, 2'd1, 1'b0, 1'b0, '0, d, c);
    check("R10 cfg after erased reset", d, 32'h4003);
    check("R3 register access cycles", c, 2);
    rdReg(4'h2, d); check("R10 baseh", d, 32'h00FF);
    rdReg(4'h4, d); check("R10 basel", d, 32'hF000);
    rdReg(4'h6, d); check("R10 ctl cleared", d, 32'h0);

    acc(24'hFFF000, 2'd0, 0, 1, '0, d, c);
    check("R12 erased byte", d, 32'hFF);
    check("R3 byte cycles W=3", c, 5);
    acc(24'hFFF000, 2'd0, 0, 0, '0, d, c);
    check("R2 data space refused", c, 0);

    // relocate window to 0x012000, no waits, both spaces
    wrReg(4'h0, 16'h0000); wrReg(4'h2, 16'h0001); wrReg(4'h4, 16'h2000);
    acc(24'h012000, 2'd0, 0, 0, '0, d, c);
    check("R1 new window hit", c, 2);
    check("R2 data space allowed", d, 32'hFF);
    acc(24'h013000, 2'd0, 0, 1, '0, d, c); check("R1 above window", c, 0);
    acc(24'h011FFF, 2'd0, 0, 1, '0, d, c); check("R1 below window", c, 0);
    acc(24'hFFF000, 2'd0, 0, 1, '0, d, c); check("R1 old window", c, 0);

    // interlocks (R6)
    acc(24'h012010, 2'd0, 1, 1, 32'h00, d, c);
    check("R6 unarmed write acked", c, 2);
    rdReg(4'h6, d); check("R6 error set unarmed", d, 32'h80);
    acc(24'h012010, 2'd0, 0, 1, '0, d, c); check("R6 unarmed no change", d, 32'hFF);
    wrReg(4'h6, 16'h0080); rdReg(4'h6, d); check("R7 error cleared", d, 32'h0);
    wrReg(4'h6, 16'h0001);
    acc(24'h012010, 2'd0, 1, 1, 32'h00, d, c);
    rdReg(4'h6, d); check("R6 error without voltage", d, 32'h81);
    acc(24'h012010, 2'd0, 0, 1, '0, d, c); check("R6 no voltage no change", d, 32'hFF);
    pgmVoltEn = 1; wrReg(4'h6, 16'h0081);

    // programming (R5) and data format (R4)
    acc(24'h012010, 2'd0, 1, 1, 32'h5A, d, c);
    acc(24'h012010, 2'd0, 0, 1, '0, d, c); check("R5 program byte", d, 32'h5A);
    acc(24'h012010, 2'd0, 1, 1, 32'hF0, d, c);
    acc(24'h012010, 2'd0, 0, 1, '0, d, c); check("R5 and of old and new", d, 32'h50);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      v = 8'((i * 37 + 11) & 255);
      acc(24'h012100 + 24'(i), 2'd0, 1, 1, {24'b0, v}, d, c);
      acc(24'h012100 + 24'(i), 2'd0, 0, 1, '0, d, c);
      check("R5 byte sweep", d, {24'b0, v});
    end
    acc(24'h012020, 2'd1, 1, 1, 32'h1234, d, c);
    acc(24'h012020, 2'd1, 0, 1, '0, d, c); check("R4 word read", d, 32'h1234);
    acc(24'h012020, 2'd2, 0, 1, '0, d, c); check("R4 long read", d, 32'h1234FFFF);
    check("R3 long cycles W=0", c, 4);
    acc(24'h012021, 2'd0, 0, 1, '0, d, c); check("R4 odd byte", d, 32'h34);
    acc(24'h012022, 2'd1, 0, 1, '0, d, c); check("R4 upper word", d, 32'hFFFF);

    // misalignment (R7)
    acc(24'h012022, 2'd2, 0, 1, '0, d, c);
    check("R7 misaligned long data", d, 32'h0);
    check("R7 misaligned long acked", c, 4);
    rdReg(4'h6, d); check("R7 misaligned sets error", d, 32'h81);
    wrReg(4'h6, 16'h0081);
    acc(24'h012011, 2'd1, 1, 1, 32'h0000, d, c);
    acc(24'h012010, 2'd1, 0, 1, '0, d, c); check("R7 odd word write ignored", d, 32'h50FF);
    acc(24'h012100, 2'd2, 1, 1, 32'h0, d, c);
    acc(24'h012100, 2'd0, 0, 1, '0, d, c); check("R7 long write ignored", d, 32'h0B);
    rdReg(4'h6, d); check("R7 long write error", d, 32'h81);
    wrReg(4'h6, 16'h0081);

    // wait-state sweep (R3)
    for (int w = 0; w < 4; w++) begin
      wrReg(4'h0, 16'(w));
      for (int s = 0; s < 3; s++) begin
        acc(24'h012020, 2'(s), 0, 1, '0, d, c);
        check("R3 wait sweep", c, (s == 2) ? 2 * (2 + w) : 2 + w);
      end
    end
    wrReg(4'h0, 16'h0000);

    // erase (R8)
    acc(24'h012400, 2'd0, 1, 1, 32'h00, d, c);
    acc(24'h012800, 2'd0, 1, 1, 32'h00, d, c);
    wrReg(4'h6, 16'h0002);
    acc(24'h012455, 2'd0, 1, 1, 32'h00, d, c);
    acc(24'h012400, 2'd0, 0, 1, '0, d, c); check("R8 block erased", d, 32'hFF);
    acc(24'h012800, 2'd0, 0, 1, '0, d, c); check("R8 other block kept", d, 32'h00);
    acc(24'h012010, 2'd0, 0, 1, '0, d, c); check("R8 block0 kept", d, 32'h50);
    wrReg(4'h6, 16'h0003);
    acc(24'h012800, 2'd0, 1, 1, 32'h00, d, c);
    rdReg(4'h6, d); check("R6 both armed error", d, 32'h83);
    wrReg(4'h6, 16'h0086);
    acc(24'h012000, 2'd0, 1, 1, 32'h00, d, c);
    acc(24'h012800, 2'd0, 0, 1, '0, d, c); check("R8 bulk erase", d, 32'hFF);
    acc(24'h012010, 2'd0, 0, 1, '0, d, c); check("R8 bulk erase block0", d, 32'hFF);

    // owner mode (R9)
    wrReg(4'h6, 16'h0001);
    wrReg(4'h0, 16'h2000);
    rdReg(4'h0, d); check("R9 owner refused while armed", d, 32'h0);
    check("R9 owner port low", 32'(ownerMode), 32'h0);
    wrReg(4'h6, 16'h0000); wrReg(4'h0, 16'h2000);
    rdReg(4'h0, d); check("R9 owner entered", d, 32'h2000);
    check("R9 owner port high", 32'(ownerMode), 32'h1);
    acc(24'h012000, 2'd0, 0, 1, '0, d, c); check("R9 array off bus", c, 0);
    wrReg(4'h6, 16'h0001);
    rdReg(4'h6, d); check("R9 arming refused", d, 32'h0);
    wrReg(4'h0, 16'h0000);

    // shadow row and reload (R10)
    wrReg(4'h6, 16'h0001);
    wrReg(4'h8, 16'h0001); wrReg(4'hA, 16'h0003); wrReg(4'hC, 16'h5000);
    wrReg(4'h8, 16'hFFFF);
    rdReg(4'h8, d); check("R10 shadow and-programmed", d, 32'h0001);
    rstPulse(1'b0);
    rdReg(4'h0, d); check("R10 cfg reloaded", d, 32'h0001);
    rdReg(4'h2, d); check("R10 baseh reloaded", d, 32'h0003);
    rdReg(4'h4, d); check("R10 basel reloaded", d, 32'h5000);
    rdReg(4'h6, d); check("R10 ctl cleared", d, 32'h0);
    acc(24'h035000, 2'd0, 0, 0, '0, d, c);
    check("R10 reloaded window", d, 32'hFF);
    check("R3 byte cycles W=1", c, 3);

    // stop bit (R11)
    wrReg(4'h6, 16'h0006);
    acc(24'h035000, 2'd0, 1, 1, 32'h0, d, c);
    rdReg(4'h8, d); check("R8 bulk erases shadow", d, 32'hFFFF);
    rstPulse(1'b0);
    rdReg(4'h0, d); check("R11 stop without strap", d, 32'hC003);
    acc(24'hFFF000, 2'd0, 0, 1, '0, d, c); check("R11 stopped array", c, 0);
    rstPulse(1'b1);
    rdReg(4'h0, d); check("R11 strap enables", d, 32'h4003);
    acc(24'hFFF000, 2'd0, 0, 1, '0, d, c); check("R11 enabled array", c, 5);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule